// File: doc/BRIEF.md
# Recursive Vertical-Crosswise Unsigned Multiplier

This block multiplies two unsigned operands of `W` bits and returns the full `2*W`-bit product on a registered output one clock after the operands are presented. The arithmetic uses quadrant decomposition. Each operand is halved, and the four half-width products are computed by smaller copies of the same structure. The recursion stops at a 2x2 cell that forms its product by vertical and crosswise bit products.

At every level the four partial products are merged the same way. The low half of the low-by-low product passes straight into the result. A 3:2 compressor folds the upper part of low-by-low together with the two cross products. A carry-select adder resolves the compressor output and yields the next `W/2` result bits. A second carry-select adder adds the remaining upper bits to the high-by-high product to give the top `W` bits.

The width is a parameter and must be a power of two, 2 or greater. The default of 16 is the production width. Instances at 8 and 2 bits let the lower levels be checked on their own, including exhaustively.

Top module: `vxmul_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `prod` is loaded with zero, whatever the operands are.
- R2: With `rst` low, `prod` after a rising edge equals the exact unsigned product of the `op_a` and `op_b` values sampled at that edge, so the latency is one cycle.
- R3: The lowest `W/2` bits of `prod` equal the lowest `W/2` bits of the product of the lower operand halves.
- R4: All-ones times all-ones gives the maximum product `{W-1 ones, 0, W-1 zeros, 1}`, which is 0xFFFE0001 at `W`=16.
- R5: If either operand is zero, `prod` is zero on the next cycle.
- R6: If `op_b` is one, `prod` on the next cycle equals `op_a` zero-extended to `2*W` bits.
- R7: Carries that ripple across every 4-bit block boundary of both merging adders give the exact product; these are the cases where one operand is all ones, or where a single bit is walked against an all-ones operand.
- R8: At `W`=8, all 65536 operand pairs give the exact product.
- R9: At `W`=2, where only the 2x2 vertical-crosswise cell is used, all 16 operand pairs give the exact product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the product register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset; clears the product register |
| op_a | input | W | Unsigned multiplicand |
| op_b | input | W | Unsigned multiplier |
| prod | output | 2*W | Registered unsigned product |

## Verification
The bound checker checks the following properties on every non-reset cycle:
- the one-cycle relation between the sampled operands and the exact product;
- the low-half pass-through;
- the all-ones result;
- the zero-operand result;
- the unit-multiplier result.

Some properties can only be shown by the bench's scenarios:
- the reset clearing of the register;
- that the carry-select blocks resolve long carry chains for the chosen walking-bit and all-ones patterns;
- that the 8-bit and 2-bit instances are exact for every input pair.

// File: rtl/vx_pkg.sv
package vx_pkg;
  // width of one carry-select block in the merging adders
  localparam int CSEL_BLK = 4;
endpackage

// File: rtl/vx_cell2.sv
// 2x2 leaf: vertical product for bit 0, crosswise sum for bit 1,
// vertical product of the upper bits plus crosswise carry for bits 3..2.
module vx_cell2 (
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [3:0] p
);
  logic x_lo_hi, x_hi_lo, mid_cy, top_pp;

  assign x_lo_hi = a[0] & b[1];
  assign x_hi_lo = a[1] & b[0];
  assign mid_cy  = x_lo_hi & x_hi_lo;
  assign top_pp  = a[1] & b[1];

  assign p[0] = a[0] & b[0];
  assign p[1] = x_lo_hi ^ x_hi_lo;
  assign p[2] = top_pp ^ mid_cy;
  assign p[3] = top_pp & mid_cy;
endmodule

// File: rtl/vx_csa3.sv
// 3:2 compressor: bitwise sum and majority (carry, not yet shifted).
module vx_csa3 #(
  parameter int WD = 8
) (
  input  logic [WD-1:0] x,
  input  logic [WD-1:0] y,
  input  logic [WD-1:0] z,
  output logic [WD-1:0] sv,
  output logic [WD-1:0] cv
);
  assign sv = x ^ y ^ z;
  assign cv = (x & y) | (x & z) | (y & z);
endmodule

// File: rtl/vx_csel_add.sv
// Carry-select adder: block 0 ripples, every upper block precomputes
// both carry-in cases and a mux picks one. Result includes carry out.
module vx_csel_add #(
  parameter int WD  = 8,
  parameter int BLK = vx_pkg::CSEL_BLK
) (
  input  logic [WD-1:0] a,
  input  logic [WD-1:0] b,
  output logic [WD:0]   s
);
  localparam int NB = (WD + BLK - 1) / BLK;

  logic [NB:0] cy;
  assign cy[0] = 1'b0;

  for (genvar i = 0; i < NB; i++) begin : gen_blk
    localparam int LO = i * BLK;
    localparam int BW = ((WD - LO) < BLK) ? (WD - LO) : BLK;
    if (i == 0) begin : gen_first
      assign {cy[1], s[LO +: BW]} = {1'b0, a[LO +: BW]} + {1'b0, b[LO +: BW]};
    end else begin : gen_sel
      logic [BW:0] r0, r1;
      assign r0 = {1'b0, a[LO +: BW]} + {1'b0, b[LO +: BW]};
      assign r1 = {1'b0, a[LO +: BW]} + {1'b0, b[LO +: BW]} + (BW+1)'(1);
      assign {cy[i+1], s[LO +: BW]} = cy[i] ? r1 : r0;
    end
  end

  assign s[WD] = cy[NB];
endmodule

// File: rtl/vx_merge.sv
// Combines four half-width products (each W bits) into a 2W-bit product.
module vx_merge #(
  parameter int W = 16
) (
  input  logic [W-1:0]   ll,
  input  logic [W-1:0]   hl,
  input  logic [W-1:0]   lh,
  input  logic [W-1:0]   hh,
  output logic [2*W-1:0] p
);
  localparam int H = W / 2;

  logic [W-1:0] ll_up, sv, cv;
  logic [W:0]   mid_r, hi_r;
  logic [H:0]   mid_up;

  assign ll_up = W'(ll[W-1:H]);

  vx_csa3 #(.WD(W)) u_csa (
    .x (ll_up),
    .y (hl),
    .z (lh),
    .sv(sv),
    .cv(cv)
  );

  // middle sum: compressor sum plus shifted majority; the majority bit
  // that shifts out at weight 2^W is kept aside and folded back below
  vx_csel_add #(.WD(W)) u_mid (
    .a(sv),
    .b({cv[W-2:0], 1'b0}),
    .s(mid_r)
  );

  // total of the three terms fits in W+1 bits, so both weight-2^W bits
  // can never be set together and an OR combines them exactly
  assign mid_up = {mid_r[W] | cv[W-1], mid_r[W-1:H]};

  vx_csel_add #(.WD(W)) u_hi (
    .a(hh),
    .b(W'(mid_up)),
    .s(hi_r)
  );

  // the upper adder's carry out is always zero for an exact product
  assign p = {hi_r[W-1] | hi_r[W], hi_r[W-2:0], mid_r[H-1:0], ll[H-1:0]};
endmodule

// File: rtl/vx_mul.sv
// Recursive quadrant multiplier, combinational. W is a power of two >= 2.
module vx_mul #(
  parameter int W = 16
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  if (W == 2) begin : gen_leaf
    vx_cell2 u_cell (.a(a), .b(b), .p(p));
  end else begin : gen_split
    localparam int H = W / 2;
    logic [W-1:0] ll, hl, lh, hh;

    vx_mul #(.W(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(ll));
    vx_mul #(.W(H)) u_hl (.a(a[W-1:H]), .b(b[H-1:0]), .p(hl));
    vx_mul #(.W(H)) u_lh (.a(a[H-1:0]), .b(b[W-1:H]), .p(lh));
    vx_mul #(.W(H)) u_hh (.a(a[W-1:H]), .b(b[W-1:H]), .p(hh));

    vx_merge #(.W(W)) u_merge (
      .ll(ll), .hl(hl), .lh(lh), .hh(hh), .p(p)
    );
  end
endmodule

// File: rtl/vxmul_top.sv
module vxmul_top #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [2*W-1:0] prod
);
  logic [2*W-1:0] prod_c;

  vx_mul #(.W(W)) u_mul (.a(op_a), .b(op_b), .p(prod_c));

  always_ff @(posedge clk) begin
    if (rst) prod <= '0;
    else     prod <= prod_c;
  end
endmodule

// File: rtl/vxmul_chk.sv
module vxmul_chk #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst,
  input logic [W-1:0]   op_a,
  input logic [W-1:0]   op_b,
  input logic [2*W-1:0] prod
);
  localparam int H = W / 2;
  localparam logic [2*W-1:0] MAXP = {{(W-1){1'b1}}, 1'b0, {(W-1){1'b0}}, 1'b1};

  logic [2*W-1:0] ref_full;
  logic [H-1:0]   ref_low;
  assign ref_full = (2*W)'(op_a) * (2*W)'(op_b);
  assign ref_low  = op_a[H-1:0] * op_b[H-1:0];

  // R2
  prod_match_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (prod == $past(ref_full)));

  // R3
  low_half_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (prod[H-1:0] == $past(ref_low)));

  // R4
  max_prod_chk: assert property (@(posedge clk) disable iff (rst)
    ((&op_a) && (&op_b)) |=> (prod == MAXP));

  // R5
  zero_op_chk: assert property (@(posedge clk) disable iff (rst)
    ((op_a == '0) || (op_b == '0)) |=> (prod == '0));

  // R6
  unit_op_chk: assert property (@(posedge clk) disable iff (rst)
    (op_b == W'(1)) |=> (prod == (2*W)'($past(op_a))));
endmodule

bind vxmul_top vxmul_chk #(.W(W)) u_chk (
  .clk (clk),
  .rst (rst),
  .op_a(op_a),
  .op_b(op_b),
  .prod(prod)
);

// File: tb/vxmul_top_tb_top.sv
module vxmul_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a16 = '0, b16 = '0;
  logic [31:0] p16;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [15:0] p8;
  logic [1:0]  a2 = '0, b2 = '0;
  logic [3:0]  p2;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vxmul_top #(.W(16)) dut_i  (.clk(clk), .rst(rst), .op_a(a16), .op_b(b16), .prod(p16));
  vxmul_top #(.W(8))  dut8_i (.clk(clk), .rst(rst), .op_a(a8),  .op_b(b8),  .prod(p8));
  vxmul_top #(.W(2))  dut2_i (.clk(clk), .rst(rst), .op_a(a2),  .op_b(b2),  .prod(p2));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at the falling edge, sample just after the capturing rising edge
  task automatic run16(input logic [15:0] x, input logic [15:0] y, input string req);
    @(negedge clk);
    a16 = x; b16 = y;
    @(posedge clk); #1;
    chk(req, 64'(p16), 64'({16'b0, x} * {16'b0, y}));
  endtask

  task automatic t_reset;
    a16 = 16'hFFFF; b16 = 16'hFFFF; a8 = 8'hFF; b8 = 8'hFF; a2 = 2'h3; b2 = 2'h3;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 p16", 64'(p16), 64'h0);
    chk("R1 p8",  64'(p8),  64'h0);
    chk("R1 p2",  64'(p2),  64'h0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R4 p16 max", 64'(p16), 64'hFFFE0001);
    chk("R4 p8 max",  64'(p8),  64'hFE01);
    chk("R4 p2 max",  64'(p2),  64'h9);
  endtask

  task automatic t_corner;
    run16(16'h0000, 16'hBEEF, "R5 zero a");
    run16(16'h1234, 16'h0000, "R5 zero b");
    run16(16'hFFFF, 16'hFFFF, "R4 ones");
    run16(16'hC0DE, 16'h0001, "R6 unit");
    run16(16'hFFFF, 16'h0001, "R6 unit ones");
    run16(16'h8000, 16'h8000, "R2 top bits");
  endtask

  task automatic t_carry;
    run16(16'h00FF, 16'hFF00, "R7 halves");
    run16(16'hFF00, 16'hFF00, "R7 high halves");
    run16(16'hFFFF, 16'h8001, "R7 ends");
    run16(16'hAAAA, 16'h5555, "R7 alternating");
    run16(16'h0F0F, 16'hF0F0, "R7 nibbles");
    for (int i = 0; i < 16; i++) begin
      run16(16'(1 << i), 16'hFFFF, "R7 walk");
      run16(16'hFFFF - 16'(1 << i), 16'hFFFF, "R7 walk hole");
    end
  endtask

  task automatic t_low_half;
    logic [15:0] x, y;
    logic [7:0]  lo;
    for (int i = 0; i < 8; i++) begin
      x = 16'h5A00 | 16'(8'h11 * i);
      y = 16'hA500 | 16'(8'h1F + 8'(i * 29));
      lo = x[7:0] * y[7:0];
      run16(x, y, "R2 low-half vector");
      chk("R3 low half", 64'(p16[7:0]), 64'(lo));
    end
  endtask

  task automatic t_random16;
    logic [31:0] r;
    for (int i = 0; i < 2000; i++) begin
      r = $urandom;
      run16(r[15:0], r[31:16], "R2 random");
    end
  endtask

  task automatic t_exhaust8;
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        @(negedge clk);
        a8 = 8'(i); b8 = 8'(j);
        @(posedge clk); #1;
        chk("R8 w8", 64'(p8), 64'(i * j));
      end
    end
  endtask

  task automatic t_cell2;
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        @(negedge clk);
        a2 = 2'(i); b2 = 2'(j);
        @(posedge clk); #1;
        chk("R9 w2", 64'(p2), 64'(i * j));
      end
    end
  endtask

  initial begin
    t_reset();
    t_corner();
    t_carry();
    t_low_half();
    t_random16();
    t_cell2();
    t_exhaust8();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule